// File: doc/BRIEF.md
# Quad 8-Bit DAC Serial Command Interface

This block is the digital front end of a four-channel 8-bit converter. A host shifts 12-bit command words into it over a three-wire serial link: an active-low select, a serial clock and a data line. Each word carries a 2-bit channel address, a 2-bit control code and an 8-bit data byte. The block keeps a staging (input) register and an output (DAC) register per channel. Depending on the code, a word writes one channel's staging register alone or together with its output register, drives one byte onto all outputs, copies every staging register to its output, changes the daisy-chain edge mode, or does nothing. An active-low load pin also copies all staging registers to the outputs.

The serial inputs are treated as slow asynchronous signals. They are synchronised into the system clock domain and their edges are detected there, so the whole block runs on one clock. A serial data output repeats each bit twelve serial clocks after it entered. Several devices can therefore be chained, and the edge on which that output changes is chosen by command.

Top module: `qdac_serial_if`

## Requirements
- R1: After synchronous reset every staging and output register reads 0x00, `dout` is 0, and the daisy-chain output follows the rising-edge mode.
- R2: While `cs_n` is low, `din` is captured MSB first on each rising `sclk` edge. A word takes effect on the rising edge of `cs_n` only if at least 12 bits were captured since `cs_n` fell, and then only the last 12 bits count. Bits [11:10] are the address (00..11 select channel 0..3), bits [9:8] are the control code and bits [7:0] are the data. Outputs reflect the word no more than 4 `clk` cycles after `cs_n` rises.
- R3: Code 11 writes the data to both the staging and the output register of the addressed channel.
- R4: Code 01 writes the data to the addressed channel's staging register only. Every output stays unchanged.
- R5: Code 00 with address bit 0 set changes no register.
- R6: Code 00 with address bit 0 clear writes the data to all four output registers and leaves the staging registers untouched.
- R7: Code 10 with address bit 1 clear copies each staging register into its output register.
- R8: Code 10 with address bit 1 set selects the daisy-chain mode from address bit 0: 0 means falling-edge mode, 1 means rising-edge mode.
- R9: While `ld_n` is low, each output register is loaded from its staging register.
- R10: `dout` carries the bit that left the 12-bit shift register on a rising `sclk` edge, which is the bit captured 12 rising edges earlier. In rising-edge mode it changes at that rising edge. In falling-edge mode it changes at the next falling edge.
- R11: `sclk` edges while `cs_n` is high neither shift data nor change `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low; a rising edge ends a word |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in, MSB first |
| ld_n | input | 1 | Active-low load of all outputs from staging registers |
| dout | output | 1 | Daisy-chain serial data out |
| dac_q | output | NCH*DW | Output registers, channel 0 in the low byte |

## Verification
Words are sent with every control code and all four addresses, with distinct data per channel. A copy after each word exposes the hidden staging registers, which separates a staging-only write from a staging-plus-output write, a broadcast and a no-op. A word cut to 11 bits and one stretched to 16 bits show the length rule and the use of the last 12 bits. Pairs of no-op words whose final bits differ show the 12-bit delay in each daisy-chain mode. Clocking with the select high, then reading back through the chain, shows that those edges were ignored.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  // control field of a command word
  typedef enum logic [1:0] {
    CTL_WIDE   = 2'b00,  // broadcast (addr[0]=0) or no-op (addr[0]=1)
    CTL_STAGE  = 2'b01,  // staging register only
    CTL_SYS    = 2'b10,  // copy-all (addr[1]=0) or edge mode (addr[1]=1)
    CTL_DIRECT = 2'b11   // staging and output register
  } ctl_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_rise,
  output logic [W-1:0] q_fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev <= chain[STAGES-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_rise = q & ~prev;
  assign q_fall = ~q & prev;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
  parameter int WORD_W = 12,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din,
  input  logic              mode_rise,
  output logic [WORD_W-1:0] word,
  output logic              full,
  output logic              dout
);
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              shout;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      cnt   <= '0;
      shout <= 1'b0;
      dout  <= 1'b0;
    end else begin
      if (cs_start) begin
        cnt <= '0;
      end else if (cs_act && sclk_rise) begin
        sr    <= {sr[WORD_W-2:0], din};
        shout <= sr[WORD_W-1];
        if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
        if (mode_rise) dout <= sr[WORD_W-1];
      end
      if (cs_act && sclk_fall && !mode_rise) dout <= shout;
    end
  end

  assign word = sr;
  assign full = (cnt == CNT_W'(WORD_W));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> ($stable(sr) && $stable(dout)));
  // R10
  dout_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && !sclk_fall) |=> $stable(dout));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WORD_W));
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank import quad_dac_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  logic [AW-1:0]     addr,
  input  ctl_e              ctl,
  input  logic [DW-1:0]     data,
  input  logic              load_act,
  output logic [NCH*DW-1:0] dac_q,
  output logic              mode_rise
);
  logic [DW-1:0] in_q [NCH];

  logic do_bcast, do_copy, do_mode;
  assign do_bcast = exec && (ctl == CTL_WIDE) && !addr[0];
  assign do_copy  = (exec && (ctl == CTL_SYS) && !addr[1]) || load_act;
  assign do_mode  = exec && (ctl == CTL_SYS) && addr[1];

  always_ff @(posedge clk) begin
    if (rst) mode_rise <= 1'b1;
    else if (do_mode) mode_rise <= addr[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit, wr_stage, wr_direct;
    assign hit       = exec && (addr == AW'(i));
    assign wr_stage  = hit && ctl[0];
    assign wr_direct = hit && (ctl == CTL_DIRECT);

    always_ff @(posedge clk) begin
      if (rst) begin
        in_q[i]             <= '0;
        dac_q[i*DW +: DW]   <= '0;
      end else begin
        if (wr_stage) in_q[i] <= data;
        if (wr_direct || do_bcast) dac_q[i*DW +: DW] <= data;
        else if (do_copy)          dac_q[i*DW +: DW] <= in_q[i];
      end
    end

    // R3
    direct_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (exec && ctl == CTL_DIRECT && addr == AW'(i)) |=>
        (dac_q[i*DW +: DW] == $past(data) && in_q[i] == $past(data)));
    // R6
    bcast_wr_chk: assert property (@(posedge clk) disable iff (rst)
      (exec && ctl == CTL_WIDE && !addr[0]) |=>
        (dac_q[i*DW +: DW] == $past(data) && $stable(in_q[i])));
    // R9
    pin_load_chk: assert property (@(posedge clk) disable iff (rst)
      (load_act && !exec) |=> dac_q[i*DW +: DW] == $past(in_q[i]));
  end

  // R4
  stage_only_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && ctl == CTL_STAGE && !load_act) |=> $stable(dac_q));
  // R5
  nop_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && ctl == CTL_WIDE && addr[0] && !load_act) |=> ($stable(dac_q) && $stable(mode_rise)));
  // R8
  mode_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && ctl == CTL_SYS && addr[1]) |=> mode_rise == $past(addr[0]));
endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if import quad_dac_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(NCH),
  localparam int WORD_W = AW + 2 + DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              ld_n,
  output logic              dout,
  output logic [NCH*DW-1:0] dac_q
);
  // bit order: {ld_n, din, sclk, cs_n}
  logic [3:0] s_q, s_rise, s_fall;

  qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .d({ld_n, din, sclk, cs_n}),
    .q(s_q), .q_rise(s_rise), .q_fall(s_fall)
  );

  logic [WORD_W-1:0] word;
  logic full, mode_rise, exec;

  qdac_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst),
    .cs_act(!s_q[0]), .cs_start(s_fall[0]),
    .sclk_rise(s_rise[1]), .sclk_fall(s_fall[1]),
    .din(s_q[2]), .mode_rise(mode_rise),
    .word(word), .full(full), .dout(dout)
  );

  assign exec = s_rise[0] && full;

  qdac_regbank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .exec(exec),
    .addr(word[WORD_W-1 -: AW]),
    .ctl(ctl_e'(word[DW+1:DW])),
    .data(word[DW-1:0]),
    .load_act(!s_q[3]),
    .dac_q(dac_q), .mode_rise(mode_rise)
  );

  // R2
  short_word_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rise[0] && !full && s_q[3]) |=> $stable(dac_q));
endmodule

// File: tb/qdac_serial_if_tb.sv
module qdac_serial_if_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ld_n = 1'b1;
  logic dout;
  logic [31:0] dac_q;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  qdac_serial_if u_dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
    .din(din), .ld_n(ld_n), .dout(dout), .dac_q(dac_q));

  // ---------------- behavioural reference model ----------------
  logic [3:0] h0, h1, hp;
  bit sq[$];
  int cnt, inr[4], dacr[4];
  bit mode, shout, m_dout;

  task automatic model_reset();
    h0 = 4'b1001; h1 = 4'b1001; hp = 4'b1001;
    sq.delete(); for (int i = 0; i < 12; i++) sq.push_back(1'b0);
    cnt = 0; mode = 1; shout = 0; m_dout = 0;
    for (int i = 0; i < 4; i++) begin inr[i] = 0; dacr[i] = 0; end
  endtask

  task automatic model_step();
    logic [3:0] rs, fl;
    int old_in[4];
    bit old_mode, old_shout, head;
    rs = h1 & ~hp; fl = ~h1 & hp;
    old_mode = mode; old_shout = shout; head = sq[0];
    for (int i = 0; i < 4; i++) old_in[i] = inr[i];
    if (!h1[3]) for (int i = 0; i < 4; i++) dacr[i] = old_in[i];
    if (rs[0] && cnt >= 12) begin
      int a, c, d;
      a = sq[0]*2 + sq[1]; c = sq[2]*2 + sq[3]; d = 0;
      for (int k = 4; k < 12; k++) d = d*2 + sq[k];
      case (c)
        3: begin inr[a] = d; dacr[a] = d; end
        1: inr[a] = d;
        0: if (a % 2 == 0) for (int i = 0; i < 4; i++) dacr[i] = d;
        default: if (a >= 2) mode = a[0];
                 else for (int i = 0; i < 4; i++) dacr[i] = old_in[i];
      endcase
    end
    if (fl[0]) cnt = 0;
    else if (!h1[0] && rs[1]) begin
      shout = head;
      void'(sq.pop_front()); sq.push_back(h1[2]);
      if (cnt < 12) cnt++;
      if (old_mode) m_dout = head;
    end
    if (!h1[0] && fl[1] && !old_mode) m_dout = old_shout;
    hp = h1; h1 = h0; h0 = {ld_n, din, sclk, cs_n};
  endtask

  always @(negedge clk) begin
    if (rst) model_reset();
    else begin
      model_step();
      n_chk++;
      if (dout !== m_dout) begin
        n_err++;
        $display("FAIL R10 model dout actual=%0b expected=%0b at %0t", dout, m_dout, $time);
      end
      for (int i = 0; i < 4; i++)
        if (dac_q[i*8 +: 8] !== 8'(dacr[i])) begin
          n_err++;
          $display("FAIL R2 model dac%0d actual=%02h expected=%02h at %0t", i, dac_q[i*8 +: 8], dacr[i], $time);
        end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(logic [31:0] w, int n);
    cs_n = 1'b0; tick(4);
    for (int b = n - 1; b >= 0; b--) begin
      din = w[b]; sclk = 1'b0; tick(4);
      sclk = 1'b1; tick(4);
    end
    sclk = 1'b0; tick(4);
    cs_n = 1'b1; tick(8);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    tick(4); rst = 1'b0; tick(2);
    // R1 reset state
    for (int i = 0; i < 4; i++) chk("R1 dac after reset", dac_q[i*8 +: 8], 8'h00);
    chk("R1 dout after reset", {7'd0, dout}, 8'h00);
    // R3 direct writes to each channel
    send(32'h311, 12); send(32'h722, 12); send(32'hB33, 12); send(32'hF44, 12);
    chk("R3 ch0", dac_q[7:0], 8'h11);   chk("R3 ch1", dac_q[15:8], 8'h22);
    chk("R3 ch2", dac_q[23:16], 8'h33); chk("R3 ch3", dac_q[31:24], 8'h44);
    // R4 staging only
    send(32'h55A, 12);
    chk("R4 ch1 output kept", dac_q[15:8], 8'h22);
    // R7 copy all
    send(32'h200, 12);
    chk("R7 ch1 copied", dac_q[15:8], 8'h5A);
    chk("R7 ch0 copied", dac_q[7:0], 8'h11);
    // R6 broadcast, staging untouched
    send(32'h0C3, 12);
    for (int i = 0; i < 4; i++) chk("R6 broadcast", dac_q[i*8 +: 8], 8'hC3);
    send(32'h200, 12);
    chk("R6 staging kept ch1", dac_q[15:8], 8'h5A);
    chk("R6 staging kept ch3", dac_q[31:24], 8'h44);
    // R5 no-op
    send(32'h4FF, 12);
    chk("R5 nop ch0", dac_q[7:0], 8'h11);
    send(32'h200, 12);
    chk("R5 nop staging ch2", dac_q[23:16], 8'h33);
    // R2 short and long words
    send(32'h3EE, 11);
    chk("R2 short word ignored", dac_q[7:0], 8'h11);
    send(32'hFB77, 16);
    chk("R2 last 12 bits used", dac_q[23:16], 8'h77);
    // R9 load pin
    send(32'hD99, 12);
    chk("R9 before pin", dac_q[31:24], 8'h44);
    ld_n = 1'b0; tick(3); ld_n = 1'b1; tick(6);
    chk("R9 after pin", dac_q[31:24], 8'h99);
    // R10 rising-edge mode daisy chain
    send(32'h4AB, 12); send(32'h400, 12);
    chk("R10 rising mode delay", {7'd0, dout}, 8'h01);
    // R8 falling-edge mode, then R10 chain
    send(32'hA00, 12);
    send(32'h4A6, 12); send(32'h4FF, 12);
    chk("R8 R10 falling mode delay", {7'd0, dout}, 8'h00);
    // R11 clocking while deselected
    din = 1'b0;
    for (int k = 0; k < 5; k++) begin sclk = 1'b1; tick(4); sclk = 1'b0; tick(4); end
    chk("R11 dout held", {7'd0, dout}, 8'h00);
    send(32'h400, 12);
    chk("R11 edges ignored", {7'd0, dout}, 8'h01);
    // R8 back to rising mode
    send(32'hE00, 12);
    send(32'h4AA, 12); send(32'h401, 12);
    chk("R8 rising mode restored", {7'd0, dout}, 8'h00);
    tick(4);
    report();
  end
endmodule